// File: doc/BRIEF.md
# Super I/O Configuration Port Controller

This block is the host-facing configuration front end of a legacy peripheral hub. The host reaches it through two adjacent byte-wide I/O addresses. The lower address holds the index and the upper address holds the data. After reset the block is locked. The host unlocks it by writing a fixed two-byte key to the index port. The host can then pick a logical device and program that device's activation, I/O bases and interrupt numbers through indexed registers.

Each logical device has its own register bank. The block drives every device's enable, its three I/O bases and its two IRQ numbers straight to the functional blocks behind it, with no further handshake. I/O bases are masked when they are written. Most devices take only 8-byte-aligned bases. A parameter lists the devices that accept any byte address.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the block is locked, every device is inactive, and all bases and IRQ outputs are zero.
- R2: Two back-to-back index-port writes of 0x87 unlock the block. Any other index-port write between them cancels the first 0x87, so that a new pair is needed.
- R3: While unlocked, an index-port write of 0xAA locks the block. Any other index-port write stores that value as the current index, and the block stays unlocked.
- R4: While locked, data-port writes change nothing, and both ports read 0xFF. While unlocked, the index port reads back the current index.
- R5: Index 0x07 holds the 8-bit device selector, which reads back as written. Indexes 0x30 and above reach the bank of the selected device. When the selector is at or above NUM_DEV, bank writes are dropped and bank reads return 0x00.
- R6: Bit 0 of index 0x30 is the activation bit of the selected device. It drives that device's bit of `dev_active`, and the other seven bits read as zero.
- R7: Index pairs 0x60/0x61, 0x62/0x63 and 0x64/0x65 hold the high and low bytes of bases 0, 1 and 2. Only the low BASE_W-8 bits of a high byte are kept.
- R8: For a device whose bit in LOOSE_DEVS is clear, the base mask is 0xFF8, so base bits [2:0] always stay zero. For a device whose bit is set, all 12 base bits are kept.
- R9: Index 0x70 holds IRQ 0 and index 0x72 holds IRQ 1. Each keeps its low IRQ_W bits and reads back zero-extended.
- R10: Any index other than 0x07, 0x30, 0x60 to 0x65, 0x70 and 0x72 reads 0x00, and a write to it changes no output.
- R11: A bank write changes only the selected device. All other devices' outputs are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Host write strobe, one cycle per byte |
| io_sel | input | 1 | Port select: 0 is the index port, 1 is the data port |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Read byte for the port selected by io_sel (combinational) |
| dev_active | output | NUM_DEV | Activation bit per device |
| dev_base0 | output | NUM_DEV*BASE_W | Base 0 per device, device d at bits [d*BASE_W +: BASE_W] |
| dev_base1 | output | NUM_DEV*BASE_W | Base 1 per device, same packing |
| dev_base2 | output | NUM_DEV*BASE_W | Base 2 per device, same packing |
| dev_irq0 | output | NUM_DEV*IRQ_W | IRQ 0 per device, device d at bits [d*IRQ_W +: IRQ_W] |
| dev_irq1 | output | NUM_DEV*IRQ_W | IRQ 1 per device, same packing |

## Verification
The bench builds the block with NUM_DEV = 8, BASE_W = 12, IRQ_W = 4 and LOOSE_DEVS = 8'h20. With these values an aligned device (2) and an unaligned device (5) sit next to each other, so a single low-byte write of 0x3F must read back differently on the two. With only eight devices, a selector value of 0x09 reaches the out-of-range path while still being a normal host byte. The 4-bit IRQ width exercises the truncation of the upper IRQ bits on write.

// File: rtl/sio_cfg_pkg.sv
`timescale 1ns/1ps
package sio_cfg_pkg;

  // Key bytes seen on the index port
  localparam logic [7:0] KEY_OPEN  = 8'h87;
  localparam logic [7:0] KEY_CLOSE = 8'hAA;

  // Byte returned on either port while locked
  localparam logic [7:0] LOCKED_READ = 8'hFF;

  // Register indexes
  localparam logic [7:0] IX_SELECT  = 8'h07;
  localparam logic [7:0] IX_BANK_LO = 8'h30;
  localparam logic [7:0] IX_ENABLE  = 8'h30;
  localparam logic [7:0] IX_BASE_HI = 8'h60;
  localparam logic [7:0] IX_IRQ0    = 8'h70;
  localparam logic [7:0] IX_IRQ1    = 8'h72;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_ARMED  = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_e;

  // Base mask: loose devices keep every bit, the others lose bits [2:0]
  function automatic logic [15:0] base_mask(input logic loose);
    return loose ? 16'hFFFF : 16'hFFF8;
  endfunction

  // Index of the high byte of base slot k
  function automatic logic [7:0] base_hi_ix(input int k);
    return 8'(IX_BASE_HI + 8'(2 * k));
  endfunction

  // Index of the low byte of base slot k
  function automatic logic [7:0] base_lo_ix(input int k);
    return 8'(IX_BASE_HI + 8'(2 * k + 1));
  endfunction

  // True when the index falls in the per-device bank
  function automatic logic in_bank(input logic [7:0] ix);
    return ix >= IX_BANK_LO;
  endfunction

endpackage

// File: rtl/sio_key_fsm.sv
`timescale 1ns/1ps
module sio_key_fsm
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       cfg_mode,
  output logic       key_armed,
  output logic       idx_load
);

  key_state_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= KS_LOCKED;
    end else if (idx_wr) begin
      case (st_q)
        KS_LOCKED: st_q <= (wdata == KEY_OPEN) ? KS_ARMED : KS_LOCKED;
        KS_ARMED:  st_q <= (wdata == KEY_OPEN) ? KS_OPEN  : KS_LOCKED;
        KS_OPEN:   if (wdata == KEY_CLOSE) st_q <= KS_LOCKED;
        default:   st_q <= KS_LOCKED;
      endcase
    end
  end

  assign cfg_mode  = (st_q == KS_OPEN);
  assign key_armed = (st_q == KS_ARMED);
  assign idx_load  = idx_wr && cfg_mode && (wdata != KEY_CLOSE);

endmodule

// File: rtl/sio_dev_bank.sv
`timescale 1ns/1ps
module sio_dev_bank
  import sio_cfg_pkg::*;
#(
  parameter int   BASE_W = 12,
  parameter int   IRQ_W  = 4,
  parameter logic LOOSE  = 1'b0
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [7:0]        ix,
  input  logic [7:0]        wdata,
  output logic              active,
  output logic [BASE_W-1:0] base0,
  output logic [BASE_W-1:0] base1,
  output logic [BASE_W-1:0] base2,
  output logic [IRQ_W-1:0]  irq0,
  output logic [IRQ_W-1:0]  irq1,
  output logic [7:0]        rdata
);

  localparam int          NSLOT  = 3;
  localparam int          HI_W   = BASE_W - 8;
  localparam logic [15:0] MASK16 = base_mask(LOOSE);
  localparam logic [7:0]  MASK_LO = MASK16[7:0];
  localparam logic [HI_W-1:0] MASK_HI = MASK16[BASE_W-1:8];

  logic              act_q;
  logic [BASE_W-1:0] base_q [NSLOT];
  logic [IRQ_W-1:0]  irq0_q;
  logic [IRQ_W-1:0]  irq1_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      irq0_q <= '0;
      irq1_q <= '0;
      for (int k = 0; k < NSLOT; k++) base_q[k] <= '0;
    end else if (we) begin
      if (ix == IX_ENABLE) act_q <= wdata[0];
      if (ix == IX_IRQ0)   irq0_q <= wdata[IRQ_W-1:0];
      if (ix == IX_IRQ1)   irq1_q <= wdata[IRQ_W-1:0];
      for (int k = 0; k < NSLOT; k++) begin
        if (ix == base_hi_ix(k)) base_q[k][BASE_W-1:8] <= wdata[HI_W-1:0] & MASK_HI;
        if (ix == base_lo_ix(k)) base_q[k][7:0]        <= wdata & MASK_LO;
      end
    end
  end

  always_comb begin
    logic [15:0] ext;
    rdata = 8'h00;
    if (ix == IX_ENABLE) rdata = {7'b0, act_q};
    if (ix == IX_IRQ0)   rdata = 8'(irq0_q);
    if (ix == IX_IRQ1)   rdata = 8'(irq1_q);
    for (int k = 0; k < NSLOT; k++) begin
      ext = 16'(base_q[k]);
      if (ix == base_hi_ix(k)) rdata = ext[15:8];
      if (ix == base_lo_ix(k)) rdata = ext[7:0];
    end
  end

  assign active = act_q;
  assign base0  = base_q[0];
  assign base1  = base_q[1];
  assign base2  = base_q[2];
  assign irq0   = irq0_q;
  assign irq1   = irq1_q;

endmodule

// File: rtl/sio_cfg_port.sv
`timescale 1ns/1ps
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int                 NUM_DEV    = 32,
  parameter int                 BASE_W     = 12,
  parameter int                 IRQ_W      = 4,
  parameter logic [NUM_DEV-1:0] LOOSE_DEVS = NUM_DEV'(32'h0000_0060)
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      io_wr,
  input  logic                      io_sel,
  input  logic [7:0]                io_wdata,
  output logic [7:0]                io_rdata,
  output logic [NUM_DEV-1:0]        dev_active,
  output logic [NUM_DEV*BASE_W-1:0] dev_base0,
  output logic [NUM_DEV*BASE_W-1:0] dev_base1,
  output logic [NUM_DEV*BASE_W-1:0] dev_base2,
  output logic [NUM_DEV*IRQ_W-1:0]  dev_irq0,
  output logic [NUM_DEV*IRQ_W-1:0]  dev_irq1
);

  localparam int SEL_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  // Named internal events
  logic               idx_wr;
  logic               dat_wr;
  logic               cfg_mode;
  logic               key_armed;
  logic               idx_load;
  logic               sel_ok;
  logic               bank_open;
  logic [NUM_DEV-1:0] bank_we;

  logic [7:0]       index_q;
  logic [7:0]       select_q;
  logic [SEL_W-1:0] bank_sel;
  logic [7:0]       bank_rd [NUM_DEV];
  logic [7:0]       sel_rd;

  assign idx_wr = io_wr && !io_sel;
  assign dat_wr = io_wr &&  io_sel;

  sio_key_fsm u_key (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx_wr    (idx_wr),
    .wdata     (io_wdata),
    .cfg_mode  (cfg_mode),
    .key_armed (key_armed),
    .idx_load  (idx_load)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index_q  <= 8'h00;
      select_q <= 8'h00;
    end else begin
      if (idx_load) index_q <= io_wdata;
      if (dat_wr && cfg_mode && (index_q == IX_SELECT)) select_q <= io_wdata;
    end
  end

  assign sel_ok    = (32'(select_q) < 32'(NUM_DEV));
  assign bank_sel  = select_q[SEL_W-1:0];
  assign bank_open = dat_wr && cfg_mode && sel_ok && in_bank(index_q);

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic [BASE_W-1:0] b0, b1, b2;
    logic [IRQ_W-1:0]  q0, q1;

    assign bank_we[d] = bank_open && (bank_sel == SEL_W'(d));

    sio_dev_bank #(
      .BASE_W (BASE_W),
      .IRQ_W  (IRQ_W),
      .LOOSE  (LOOSE_DEVS[d])
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (bank_we[d]),
      .ix     (index_q),
      .wdata  (io_wdata),
      .active (dev_active[d]),
      .base0  (b0),
      .base1  (b1),
      .base2  (b2),
      .irq0   (q0),
      .irq1   (q1),
      .rdata  (bank_rd[d])
    );

    assign dev_base0[d*BASE_W +: BASE_W] = b0;
    assign dev_base1[d*BASE_W +: BASE_W] = b1;
    assign dev_base2[d*BASE_W +: BASE_W] = b2;
    assign dev_irq0[d*IRQ_W +: IRQ_W]    = q0;
    assign dev_irq1[d*IRQ_W +: IRQ_W]    = q1;
  end

  always_comb begin
    sel_rd = 8'h00;
    for (int d = 0; d < NUM_DEV; d++) begin
      if (sel_ok && (bank_sel == SEL_W'(d))) sel_rd = bank_rd[d];
    end
  end

  always_comb begin
    if (!cfg_mode)                 io_rdata = LOCKED_READ;
    else if (!io_sel)              io_rdata = index_q;
    else if (index_q == IX_SELECT) io_rdata = select_q;
    else if (in_bank(index_q))     io_rdata = sel_rd;
    else                           io_rdata = 8'h00;
  end

endmodule

// File: rtl/sio_cfg_chk.sv
`timescale 1ns/1ps
module sio_cfg_chk #(
  parameter int                 NUM_DEV    = 32,
  parameter int                 BASE_W     = 12,
  parameter logic [NUM_DEV-1:0] LOOSE_DEVS = '0
)(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      io_wr,
  input logic                      io_sel,
  input logic [7:0]                io_wdata,
  input logic [7:0]                io_rdata,
  input logic                      cfg_mode,
  input logic                      key_armed,
  input logic [NUM_DEV-1:0]        bank_we,
  input logic [NUM_DEV-1:0]        dev_active,
  input logic [NUM_DEV*BASE_W-1:0] dev_base0,
  input logic [NUM_DEV*BASE_W-1:0] dev_base1,
  input logic [NUM_DEV*BASE_W-1:0] dev_base2
);

  p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !io_sel && !cfg_mode && !key_armed && io_wdata == 8'h87) |=> key_armed);

  p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !io_sel && key_armed && io_wdata == 8'h87) |=> cfg_mode);

  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !io_sel && !cfg_mode && io_wdata != 8'h87) |=> (!cfg_mode && !key_armed));

  p_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !io_sel && cfg_mode && io_wdata == 8'hAA) |=> !cfg_mode);

  p_stay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && !(io_wr && !io_sel && io_wdata == 8'hAA)) |=> cfg_mode);

  p_locked_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |-> (io_rdata == 8'hFF));

  p_locked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |=> ($stable(dev_active) && $stable(dev_base0) &&
                   $stable(dev_base1) && $stable(dev_base2)));

  p_one_bank_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we));

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_align
    if (!LOOSE_DEVS[d]) begin : g_tight
      p_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_base0[d*BASE_W +: 3] == 3'b0) && (dev_base1[d*BASE_W +: 3] == 3'b0) &&
        (dev_base2[d*BASE_W +: 3] == 3'b0));
    end
  end

endmodule

bind sio_cfg_port sio_cfg_chk #(
  .NUM_DEV    (NUM_DEV),
  .BASE_W     (BASE_W),
  .LOOSE_DEVS (LOOSE_DEVS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .io_wr      (io_wr),
  .io_sel     (io_sel),
  .io_wdata   (io_wdata),
  .io_rdata   (io_rdata),
  .cfg_mode   (cfg_mode),
  .key_armed  (key_armed),
  .bank_we    (bank_we),
  .dev_active (dev_active),
  .dev_base0  (dev_base0),
  .dev_base1  (dev_base1),
  .dev_base2  (dev_base2)
);

// File: tb/sim_sio_cfg_port.sv
`timescale 1ns/1ps
module sim_sio_cfg_port;

  localparam int ND = 8;
  localparam int BW = 12;
  localparam int IW = 4;
  localparam int NV = 26;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             io_wr = 1'b0;
  logic             io_sel = 1'b0;
  logic [7:0]       io_wdata = 8'h00;
  logic [7:0]       io_rdata;
  logic [ND-1:0]    dev_active;
  logic [ND*BW-1:0] dev_base0, dev_base1, dev_base2;
  logic [ND*IW-1:0] dev_irq0, dev_irq1;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sio_cfg_port #(
    .NUM_DEV    (ND),
    .BASE_W     (BW),
    .IRQ_W      (IW),
    .LOOSE_DEVS (8'h20)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_sel(io_sel),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .dev_active(dev_active),
    .dev_base0(dev_base0), .dev_base1(dev_base1), .dev_base2(dev_base2),
    .dev_irq0(dev_irq0), .dev_irq1(dev_irq1)
  );

  // op: 0 index write, 1 data write, 2 index read check, 3 data read check
  // fields: {op[1:0], byte[7:0], expected[7:0], requirement[7:0]}
  localparam logic [25:0] VEC [NV] = '{
    {2'd0, 8'h87, 8'h00, 8'd2},   // R2 first key byte
    {2'd0, 8'h87, 8'h00, 8'd2},   // R2 second key byte
    {2'd0, 8'h07, 8'h00, 8'd5},
    {2'd1, 8'h02, 8'h00, 8'd5},
    {2'd3, 8'h00, 8'h02, 8'd5},   // R5 selector readback
    {2'd0, 8'h30, 8'h00, 8'd6},
    {2'd1, 8'hFF, 8'h00, 8'd6},
    {2'd3, 8'h00, 8'h01, 8'd6},   // R6 only bit 0 kept
    {2'd0, 8'h60, 8'h00, 8'd7},
    {2'd1, 8'hAB, 8'h00, 8'd7},
    {2'd3, 8'h00, 8'h0B, 8'd7},   // R7 high byte keeps 4 bits
    {2'd0, 8'h61, 8'h00, 8'd8},
    {2'd1, 8'h3F, 8'h00, 8'd8},
    {2'd3, 8'h00, 8'h38, 8'd8},   // R8 aligned device
    {2'd0, 8'h70, 8'h00, 8'd9},
    {2'd1, 8'h2D, 8'h00, 8'd9},
    {2'd3, 8'h00, 8'h0D, 8'd9},   // R9 IRQ truncated
    {2'd0, 8'h07, 8'h00, 8'd8},
    {2'd1, 8'h05, 8'h00, 8'd8},
    {2'd0, 8'h61, 8'h00, 8'd8},
    {2'd1, 8'h3F, 8'h00, 8'd8},
    {2'd3, 8'h00, 8'h3F, 8'd8},   // R8 loose device
    {2'd0, 8'h40, 8'h00, 8'd10},
    {2'd1, 8'h55, 8'h00, 8'd10},
    {2'd3, 8'h00, 8'h00, 8'd10},  // R10 unimplemented index
    {2'd2, 8'h00, 8'h40, 8'd4}    // R4 index readback while open
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_sel = sel; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, input logic [7:0] exp, input string tag);
    io_sel = sel;
    #1;
    chk(32'(io_rdata), 32'(exp), tag);
  endtask

  function automatic logic [BW-1:0] bsl(input logic [ND*BW-1:0] v, input int d);
    return v[d*BW +: BW];
  endfunction

  function automatic logic [IW-1:0] isl(input logic [ND*IW-1:0] v, input int d);
    return v[d*IW +: IW];
  endfunction

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(1'b0, 8'hFF, "R1 locked after reset");
    chk(32'(dev_active), 0, "R1 inactive");
    chk(32'(dev_base0[31:0]), 0, "R1 bases clear");
    chk(32'(dev_irq0), 0, "R1 irq clear");

    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vector %0d", v[7:0], i);
      case (v[25:24])
        2'd0: wr(1'b0, v[23:16]);
        2'd1: wr(1'b1, v[23:16]);
        2'd2: rd(1'b0, v[15:8], tag);
        default: rd(1'b1, v[15:8], tag);
      endcase
    end

    // R6 R7 R8 R9 outputs at the ports
    chk(32'(dev_active), 32'h04, "R6 dev_active");
    chk(32'(bsl(dev_base0, 2)), 32'hB38, "R7 dev2 base0");
    chk(32'(isl(dev_irq0, 2)), 32'hD, "R9 dev2 irq0");
    chk(32'(bsl(dev_base0, 5)), 32'h03F, "R8 dev5 base0");

    // R3 exit, R4 locked behaviour
    wr(1'b0, 8'hAA);
    rd(1'b0, 8'hFF, "R3 index locked");
    rd(1'b1, 8'hFF, "R4 data locked");
    wr(1'b1, 8'h00);
    chk(32'(dev_active), 32'h04, "R4 locked write ignored");

    // R2 restart
    wr(1'b0, 8'h87);
    wr(1'b0, 8'h12);
    wr(1'b0, 8'h87);
    rd(1'b1, 8'hFF, "R2 interrupted key");
    wr(1'b0, 8'h87);
    rd(1'b1, 8'h00, "R2 reopened, index 40");
    rd(1'b0, 8'h40, "R3 index kept across close");

    // second base and second IRQ on device 3
    wr(1'b0, 8'h07); wr(1'b1, 8'h03);
    wr(1'b0, 8'h64); wr(1'b1, 8'h0F);
    wr(1'b0, 8'h65); wr(1'b1, 8'hFF);
    wr(1'b0, 8'h72); wr(1'b1, 8'h17);
    wr(1'b0, 8'h62);
    rd(1'b1, 8'h00, "R7 dev3 base1 untouched");
    chk(32'(bsl(dev_base2, 3)), 32'hFF8, "R7 dev3 base2");
    chk(32'(isl(dev_irq1, 3)), 32'h7, "R9 dev3 irq1");
    chk(32'(bsl(dev_base0, 2)), 32'hB38, "R11 dev2 unchanged");

    // R5 out-of-range selector
    wr(1'b0, 8'h07); wr(1'b1, 8'h09);
    rd(1'b1, 8'h09, "R5 selector 09");
    wr(1'b0, 8'h30); wr(1'b1, 8'h01);
    rd(1'b1, 8'h00, "R5 out of range read");
    chk(32'(dev_active), 32'h04, "R5 out of range write");

    // R1 mid-run reset
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    rd(1'b1, 8'hFF, "R1 locked after second reset");
    chk(32'(dev_active), 0, "R1 inactive again");
    chk(32'(bsl(dev_base2, 3)), 0, "R1 base cleared");
    chk(32'(isl(dev_irq1, 3)), 0, "R1 irq cleared");

    finish_run();
  end

endmodule